// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block turns an asynchronous serial line into parallel characters. It first passes the line through a synchronizer. It then watches the line on a 16x oversampling enable and confirms each start bit at its centre. It samples every data bit and parity bit once, at the middle of the bit. The result goes into a buffer register, together with per-character parity and framing status and an overrun flag.

The format comes from a small set of line-control inputs, the same ones the companion transmitter uses. These give a word length of 5 to 8 bits, an optional parity bit, even or odd parity, and stick (forced) parity. The consumer reads `rx_data` while `data_ready` is high. It then pulses `take` to release the buffer.

Top module: `serial_char_rx`

## Requirements
- R1: After reset, `data_ready`, `parity_err`, `frame_err` and `overrun` are 0 and `rx_data` is 0.
- R2: The word length follows `len_sel`: codes 00, 01, 10 and 11 give 5, 6, 7 and 8 data bits. The first bit received lands in `rx_data[0]`, and buffer bits above the word length read 0.
- R3: With `par_en`=1, one parity bit is expected straight after the last data bit. With `par_en`=0, no parity bit is expected and `parity_err` stays 0.
- R4: With `par_stick`=0, `parity_err` is 0 exactly when the data bits plus the parity bit hold an even number of ones (`par_even`=1) or an odd number of ones (`par_even`=0).
- R5: With `par_stick`=1, the received parity bit must equal the inverse of `par_even`: 0 when `par_even`=1 and 1 when `par_even`=0. Any other value sets `parity_err`.
- R6: Only one stop bit is checked. The start bit of the next character may follow the first stop bit directly and is received correctly.
- R7: A first stop bit sampled as 0 sets `frame_err`. The character is still stored and `data_ready` rises. The line must be seen high again before a new start bit is accepted.
- R8: A low level that is no longer low at the middle of the start bit is discarded, and no character is produced.
- R9: If a character completes while `data_ready` is 1 and `take` is 0, `overrun` is set and `rx_data` is replaced by the new character.
- R10: A `take` pulse with no character completing in the same cycle clears `data_ready`, `parity_err`, `frame_err` and `overrun` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit time |
| rxd | input | 1 | Asynchronous serial line, idle high |
| len_sel | input | 2 | Word length code (00=5 … 11=8 bits) |
| par_en | input | 1 | Expect and check a parity bit |
| par_even | input | 1 | 1: even parity, 0: odd parity |
| par_stick | input | 1 | Forced parity value, the inverse of `par_even` |
| take | input | 1 | Consumer has read the buffer |
| rx_data | output | 8 | Received character, zero-extended |
| data_ready | output | 1 | Buffer holds an unread character |
| parity_err | output | 1 | Parity check of the buffered character failed |
| frame_err | output | 1 | First stop bit of the buffered character was 0 |
| overrun | output | 1 | A character replaced one that had not been read |

## Verification
Each word length gets a character with ones above the word boundary, which shows whether upper bits are masked and whether bit order is kept. The normal-parity cases use data with opposite ones counts under both even and odd selection, each with a correct and a flipped parity bit. The stick-parity cases send both parity values under each `par_even` setting, which separates forced parity from computed parity. Further patterns cover back-to-back characters with a single stop bit, a zero stop bit, a short low glitch, and two unread characters in a row, which target the stop check, framing recovery, start validation and overrun respectively.

// File: rtl/serial_rx_pkg.sv
// Shared types and helpers for the serial character receiver.
// Assumes at most 8 data bits per character.
package serial_rx_pkg;

    localparam int MAX_BITS = 8;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    // Index of the last data bit for a word length code (5..8 bits).
    function automatic logic [2:0] last_bit_idx(input logic [1:0] code);
        return 3'd4 + {1'b0, code};
    endfunction

endpackage

// File: rtl/rx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high, so the chain resets to 1.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe;

    // Shift the line through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], d};
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/rx_parity_chk.sv
// Combinational parity checker that supports normal and stick parity.
// Assumes the data bits above the word length are already zero.
module rx_parity_chk #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          pbit,
    input  logic          en,
    input  logic          even,
    input  logic          stick,
    output logic          err
);
    logic ones_odd;

    // Decide whether the received parity bit is wrong.
    always_comb begin
        ones_odd = (^data) ^ pbit;
        if (!en)        err = 1'b0;
        else if (stick) err = (pbit != ~even);
        else if (even)  err = ones_odd;
        else            err = ~ones_odd;
    end
endmodule

// File: rtl/rx_framer.sv
// Bit-timing state machine: validates the start bit at mid-bit, samples
// data, parity and the first stop bit at their centres, and pulses done.
// Assumes tick arrives OVS times per bit and the format inputs are stable
// during a character.
module rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                line,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    output logic [MAX_BITS-1:0] data,
    output logic                par_bit,
    output logic                stop_bit,
    output logic                done
);
    localparam int CW = $clog2(OVS);
    localparam logic [CW-1:0] MID  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OVS - 1);

    rx_state_e   st;
    logic [CW-1:0] cnt;
    logic [2:0]    idx;
    logic          armed;

    // Advance the receive state machine on each oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_HUNT;
            cnt      <= '0;
            idx      <= '0;
            armed    <= 1'b0;
            data     <= '0;
            par_bit  <= 1'b0;
            stop_bit <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    ST_HUNT: begin
                        cnt <= '0;
                        if (line) armed <= 1'b1;
                        else if (armed) begin
                            st    <= ST_START;
                            armed <= 1'b0;
                        end
                    end
                    ST_START: begin
                        if (cnt == MID) begin
                            cnt <= '0;
                            if (!line) begin
                                st   <= ST_DATA;
                                idx  <= '0;
                                data <= '0;
                            end else begin
                                st <= ST_HUNT;
                            end
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_DATA: begin
                        if (cnt == LAST) begin
                            cnt       <= '0;
                            data[idx] <= line;
                            if (idx == last_bit_idx(len_sel))
                                st <= par_en ? ST_PAR : ST_STOP;
                            else
                                idx <= idx + 1'b1;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_bit <= line;
                            st      <= ST_STOP;
                        end else cnt <= cnt + 1'b1;
                    end
                    ST_STOP: begin
                        if (cnt == LAST) begin
                            cnt      <= '0;
                            stop_bit <= line;
                            done     <= 1'b1;
                            armed    <= 1'b0;
                            st       <= ST_HUNT;
                        end else cnt <= cnt + 1'b1;
                    end
                    default: st <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_char_rx.sv
// Top of the serial character receiver: synchronizer, framer, parity
// checker and the buffer register with its status flags.
// Assumes the consumer pulses take for one cycle per character read.
module serial_char_rx
    import serial_rx_pkg::*;
#(
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick16,
    input  logic                rxd,
    input  logic [1:0]          len_sel,
    input  logic                par_en,
    input  logic                par_even,
    input  logic                par_stick,
    input  logic                take,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                data_ready,
    output logic                parity_err,
    output logic                frame_err,
    output logic                overrun
);
    logic                line_s;
    logic [MAX_BITS-1:0] fr_data;
    logic                fr_par;
    logic                fr_stop;
    logic                char_done;
    logic                pe_now;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rxd),
        .q    (line_s)
    );

    rx_framer #(.OVS(OVS)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick16),
        .line    (line_s),
        .len_sel (len_sel),
        .par_en  (par_en),
        .data    (fr_data),
        .par_bit (fr_par),
        .stop_bit(fr_stop),
        .done    (char_done)
    );

    rx_parity_chk #(.DW(MAX_BITS)) u_par (
        .data (fr_data),
        .pbit (fr_par),
        .en   (par_en),
        .even (par_even),
        .stick(par_stick),
        .err  (pe_now)
    );

    // Load a finished character with its status, or release it on take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            data_ready <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end else if (char_done) begin
            rx_data    <= fr_data;
            data_ready <= 1'b1;
            parity_err <= pe_now;
            frame_err  <= ~fr_stop;
            overrun    <= data_ready & ~take;
        end else if (take) begin
            data_ready <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            overrun    <= 1'b0;
        end
    end
endmodule

// File: rtl/serial_char_rx_chk.sv
// Property checker for serial_char_rx, bound to every instance.
// Assumes it sees the internal character-complete pulse.
module serial_char_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       take,
    input logic       done,
    input logic       data_ready,
    input logic       overrun,
    input logic       frame_err,
    input logic       parity_err,
    input logic       par_en,
    input logic [1:0] len_sel,
    input logic [7:0] rx_data
);
    assert_ready_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> data_ready);

    assert_take_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !done) |=> (!data_ready && !overrun && !frame_err && !parity_err));

    assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> ($past(data_ready) && $past(done)));

    assert_short_word_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && len_sel == 2'b00) |=> (rx_data[7:5] == 3'b000));

    assert_no_parity_err_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !par_en) |=> !parity_err);

    assert_frame_err_only_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(frame_err) |-> $past(done));
endmodule

bind serial_char_rx serial_char_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .done      (char_done),
    .data_ready(data_ready),
    .overrun   (overrun),
    .frame_err (frame_err),
    .parity_err(parity_err),
    .par_en    (par_en),
    .len_sel   (len_sel),
    .rx_data   (rx_data)
);

// File: tb/tb_serial_char_rx.sv
module tb_serial_char_rx;
    localparam int OVS      = 16;
    localparam int TICK_DIV = 2;
    localparam int BIT_CLKS = OVS * TICK_DIV;

    typedef struct {
        logic [7:0] d;
        logic       pe;
        logic       fe;
        string      req;
    } item_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n     = 1'b0;
    logic       tick16    = 1'b0;
    logic       rxd       = 1'b1;
    logic [1:0] len_sel   = 2'b11;
    logic       par_en    = 1'b0;
    logic       par_even  = 1'b0;
    logic       par_stick = 1'b0;
    logic       take      = 1'b0;
    logic [7:0] rx_data;
    logic       data_ready, parity_err, frame_err, overrun;

    int    checks = 0;
    int    fails  = 0;
    bit    auto_take = 1'b1;
    item_t sb[$];

    serial_char_rx #(.OVS(OVS), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .len_sel(len_sel), .par_en(par_en), .par_even(par_even),
        .par_stick(par_stick), .take(take), .rx_data(rx_data),
        .data_ready(data_ready), .parity_err(parity_err),
        .frame_err(frame_err), .overrun(overrun)
    );

    // Oversampling enable: one pulse every TICK_DIV clocks.
    always @(negedge clk) tick16 = ~tick16;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic logic [7:0] len_mask();
        return 8'hFF >> (3 - len_sel);
    endfunction

    // Parity bit a correct transmitter would send under the current format.
    function automatic logic good_pbit(input logic [7:0] d);
        logic [7:0] m = d & len_mask();
        if (par_stick) return ~par_even;
        return par_even ? ^m : ~^m;
    endfunction

    task automatic bit_out(input logic v);
        rxd = v;
        repeat (BIT_CLKS) @(negedge clk);
    endtask

    // Driver: push the expected item, then serialise the character.
    task automatic send(input logic [7:0] d, input logic pbit, input logic stopv,
                        input string req, input bit push);
        item_t it;
        it.d   = d & len_mask();
        it.pe  = par_en && (pbit !== good_pbit(d));
        it.fe  = ~stopv;
        it.req = req;
        if (push) sb.push_back(it);
        bit_out(1'b0);
        for (int i = 0; i < 5 + int'(len_sel); i++) bit_out(d[i]);
        if (par_en) bit_out(pbit);
        bit_out(stopv);
        if (!stopv) begin
            bit_out(1'b1);
            bit_out(1'b1);
        end
    endtask

    // Monitor: pop and compare each delivered character, then release it.
    always @(negedge clk) begin
        if (take) begin
            take = 1'b0;
        end else if (rst_n && auto_take && data_ready) begin
            if (sb.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6: unexpected character actual %0h expected none", rx_data);
            end else begin
                item_t it;
                it = sb.pop_front();
                check({it.req, " data"}, rx_data, it.d);
                check({it.req, " parity_err"}, {7'd0, parity_err}, {7'd0, it.pe});
                check({it.req, " frame_err"}, {7'd0, frame_err}, {7'd0, it.fe});
            end
            take = 1'b1;
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 data_ready", {7'd0, data_ready}, 8'd0);
        check("R1 parity_err", {7'd0, parity_err}, 8'd0);
        check("R1 frame_err", {7'd0, frame_err}, 8'd0);
        check("R1 overrun", {7'd0, overrun}, 8'd0);
        check("R1 rx_data", rx_data, 8'd0);
        repeat (BIT_CLKS) @(negedge clk);

        // R2 and R6: 8-bit words, back to back with a single stop bit
        send(8'hA5, 1'b0, 1'b1, "R6 b2b first", 1);
        send(8'h3C, 1'b0, 1'b1, "R6 b2b second", 1);
        // R2 word lengths, upper bits set to show masking
        len_sel = 2'b00; send(8'hFF, 1'b0, 1'b1, "R2 len5", 1);
        len_sel = 2'b01; send(8'hC6, 1'b0, 1'b1, "R2 len6", 1);
        len_sel = 2'b10; send(8'h81, 1'b0, 1'b1, "R2 len7", 1);
        len_sel = 2'b11;

        // R4 normal parity, even and odd, correct and flipped bits
        par_en = 1'b1; par_even = 1'b1;
        send(8'h0F, good_pbit(8'h0F), 1'b1, "R4 even ok", 1);
        send(8'h07, ~good_pbit(8'h07), 1'b1, "R4 even bad", 1);
        par_even = 1'b0;
        send(8'h55, good_pbit(8'h55), 1'b1, "R4 odd ok", 1);
        send(8'h54, ~good_pbit(8'h54), 1'b1, "R4 odd bad", 1);
        // R3 parity bit placed right after a 6-bit word
        len_sel = 2'b01; par_even = 1'b1;
        send(8'h2B, good_pbit(8'h2B), 1'b1, "R3 len6 parity", 1);
        len_sel = 2'b11;

        // R5 stick parity, both values under both selections
        par_stick = 1'b1; par_even = 1'b1;
        send(8'h01, 1'b0, 1'b1, "R5 stick space ok", 1);
        send(8'h01, 1'b1, 1'b1, "R5 stick space bad", 1);
        par_even = 1'b0;
        send(8'h03, 1'b1, 1'b1, "R5 stick mark ok", 1);
        send(8'h03, 1'b0, 1'b1, "R5 stick mark bad", 1);
        par_stick = 1'b0; par_en = 1'b0;
        // R3 parity disabled: a 0 right after data is the stop bit
        send(8'hF0, 1'b0, 1'b1, "R3 no parity", 1);

        // R7 framing error, character still delivered
        send(8'h5A, 1'b0, 1'b0, "R7 frame", 1);
        wait (sb.size() == 0);
        repeat (4) @(negedge clk);
        check("R10 frame_err cleared", {7'd0, frame_err}, 8'd0);
        check("R10 data_ready cleared", {7'd0, data_ready}, 8'd0);

        // R8 short glitch is discarded
        rxd = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (3 * BIT_CLKS) @(negedge clk);
        check("R8 glitch no char", {7'd0, data_ready}, 8'd0);
        send(8'h99, 1'b0, 1'b1, "R8 after glitch", 1);
        wait (sb.size() == 0);
        repeat (4) @(negedge clk);

        // R9 overrun: two characters with no read in between
        auto_take = 1'b0;
        send(8'h11, 1'b0, 1'b1, "R9 lost", 0);
        send(8'h22, 1'b0, 1'b1, "R9 kept", 1);
        repeat (4) @(negedge clk);
        check("R9 overrun set", {7'd0, overrun}, 8'd1);
        check("R9 data replaced", rx_data, 8'h22);
        check("R9 still ready", {7'd0, data_ready}, 8'd1);
        auto_take = 1'b1;
        wait (sb.size() == 0);
        repeat (4) @(negedge clk);
        check("R10 overrun cleared", {7'd0, overrun}, 8'd0);

        finish_run();
    end
endmodule